// File: doc/BRIEF.md
# Multi-Lane 8b/10b Symbol Decoder

This block turns a group of 10-bit line symbols, received side by side in one clock, back into bytes. Each lane gets its own byte, a flag that marks one of the twelve legal control symbols, and a flag that marks a symbol that could not be decoded cleanly. A group is taken in on a rising clock edge when the input strobe is high. The decoded group appears one clock later with its own output strobe. Word alignment and framing are left to the logic upstream.

Running disparity is kept as a two-state machine with the states RD_NEG and RD_POS. Reset enters RD_NEG. Within a cycle the expected disparity ripples from lane 0 up through the last lane: each lane checks its symbol against the disparity left by the lane below it. On a cycle where the strobe is high, the machine moves to the disparity left by the last lane. That is RD_NEG to RD_POS, RD_POS to RD_NEG, or a hold in the same state. When the strobe is low the machine holds its state and the outputs keep their values. After a faulty symbol, the disparity follows what was actually received, so the decoder resynchronises by itself.

Top module: `mlane_8b10b_decoder`

## Requirements
- R1: While the active-low asynchronous reset is asserted, out_valid, out_k, out_err and out_bytes are all zero, and the expected disparity is negative.
- R2: out_valid is in_valid delayed by exactly one clock. Byte, control and error outputs are loaded only from a group captured with in_valid high. Otherwise they keep their values.
- R3: Lane i takes in_words[10i+9:10i] as the bits a,b,c,d,e,i,f,g,h,j, with a in the highest position. Bits [9:4] of the lane form the 6-bit sub-block and bits [3:0] form the 4-bit sub-block. A legal data symbol yields the byte HGFEDCBA on out_bytes[8i+7:8i], with out_k[i] low.
- R4: Each of the twelve control symbols K.28.0 to K.28.7, K.23.7, K.27.7, K.29.7 and K.30.7 sets out_k[i] and yields its byte. For example, 0011111010 and 1100000101 both give 0xBC.
- R5: A 6-bit sub-block that is not in the code table, or a 4-bit sub-block of 0000 or 1111, sets out_err[i] and clears out_k[i]. The byte is then undefined.
- R6: A sub-block whose disparity conflicts with the expected disparity sets out_err[i]. This covers two cases: a sub-block with more ones than zeros while positive, or fewer while negative. It also covers 111000 or 1100 while positive, and 000111 or 0011 while negative.
- R7: The expected disparity for lane i+1 is the one left after lane i's symbol in the same cycle.
- R8: The disparity left by the last lane is carried to lane 0 of the next captured group. Cycles with in_valid low do not change it.
- R9: After any symbol the disparity follows that symbol's sub-blocks. More ones than zeros gives positive, fewer gives negative, and an equal count leaves it unchanged. A later correct stream then decodes with no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_words | input | LANES*10 | Received symbols, lane 0 in the lowest bits |
| in_valid | input | 1 | Capture strobe for in_words |
| out_bytes | output | LANES*8 | Decoded bytes, lane 0 in the lowest bits |
| out_k | output | LANES | Per-lane control symbol flag |
| out_err | output | LANES | Per-lane decode or disparity error flag |
| out_valid | output | 1 | Strobe for the decoded group |

## Verification
Every decoded result and out_valid are due on the first rising edge after the edge that captured the group. The bench therefore drives at a falling edge and samples at the next falling edge, one register stage later. The disparity outcome of one group is seen only in the error flags of the group that follows. Table entries are therefore streamed with no gap, and each expected flag is worked out from the disparity left by the entry before. Reset clears outputs at once, so those checks sample a fraction of a period after reset is asserted, without waiting for a clock.

// File: rtl/mlane_dec_pkg.sv
package mlane_dec_pkg;

    typedef enum logic {
        RD_NEG = 1'b0,
        RD_POS = 1'b1
    } rd_e;

    localparam int SYM_W  = 10;
    localparam int BYTE_W = 8;
    localparam int HI_W   = 6;
    localparam int LO_W   = 4;

endpackage

// File: rtl/mlane_dec_six.sv
module mlane_dec_six (
    input  logic [5:0] code,
    output logic [4:0] val,
    output logic       legal,
    output logic       is_k28
);
    always_comb begin
        legal  = 1'b1;
        is_k28 = 1'b0;
        val    = 5'd0;
        unique case (code)
            6'b100111, 6'b011000: val = 5'd0;
            6'b011101, 6'b100010: val = 5'd1;
            6'b101101, 6'b010010: val = 5'd2;
            6'b110001:            val = 5'd3;
            6'b110101, 6'b001010: val = 5'd4;
            6'b101001:            val = 5'd5;
            6'b011001:            val = 5'd6;
            6'b111000, 6'b000111: val = 5'd7;
            6'b111001, 6'b000110: val = 5'd8;
            6'b100101:            val = 5'd9;
            6'b010101:            val = 5'd10;
            6'b110100:            val = 5'd11;
            6'b001101:            val = 5'd12;
            6'b101100:            val = 5'd13;
            6'b011100:            val = 5'd14;
            6'b010111, 6'b101000: val = 5'd15;
            6'b011011, 6'b100100: val = 5'd16;
            6'b100011:            val = 5'd17;
            6'b010011:            val = 5'd18;
            6'b110010:            val = 5'd19;
            6'b001011:            val = 5'd20;
            6'b101010:            val = 5'd21;
            6'b011010:            val = 5'd22;
            6'b111010, 6'b000101: val = 5'd23;
            6'b110011, 6'b001100: val = 5'd24;
            6'b100110:            val = 5'd25;
            6'b010110:            val = 5'd26;
            6'b110110, 6'b001001: val = 5'd27;
            6'b001110:            val = 5'd28;
            6'b101110, 6'b010001: val = 5'd29;
            6'b011110, 6'b100001: val = 5'd30;
            6'b101011, 6'b010100: val = 5'd31;
            6'b001111, 6'b110000: begin
                val    = 5'd28;
                is_k28 = 1'b1;
            end
            default:              legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/mlane_dec_four.sv
module mlane_dec_four (
    input  logic [3:0] code,
    output logic [2:0] val,
    output logic       legal,
    output logic       alt7
);
    always_comb begin
        legal = 1'b1;
        alt7  = 1'b0;
        val   = 3'd0;
        unique case (code)
            4'b1011, 4'b0100: val = 3'd0;
            4'b1001:          val = 3'd1;
            4'b0101:          val = 3'd2;
            4'b1100, 4'b0011: val = 3'd3;
            4'b1101, 4'b0010: val = 3'd4;
            4'b1010:          val = 3'd5;
            4'b0110:          val = 3'd6;
            4'b1110, 4'b0001: val = 3'd7;
            4'b0111, 4'b1000: begin
                val  = 3'd7;
                alt7 = 1'b1;
            end
            default:          legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/mlane_dec_lane.sv
module mlane_dec_lane
    import mlane_dec_pkg::*;
(
    input  logic [SYM_W-1:0]  sym,
    input  rd_e               rd_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              k_out,
    output logic              err_out,
    output rd_e               rd_out
);
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
    logic [LO_W-1:0] lo_val_in;
    logic [4:0]      v5;
    logic [2:0]      v3;
    logic            ok6, ok4, k28, a7;
    logic [2:0]      ones6;
    logic [2:0]      ones4;
    logic            hi_pos, hi_neg, lo_pos, lo_neg;
    logic            hi_bad_disp, lo_bad_disp;
    logic            k_shape, code_ok;
    rd_e             rd_mid;

    assign hi = sym[SYM_W-1:LO_W];
    assign lo = sym[LO_W-1:0];

    // after the negative-going control prefix the balanced tail codes are mirrored
    assign lo_val_in = (hi == 6'b110000) ? ~lo : lo;

    mlane_dec_six u_six (
        .code   (hi),
        .val    (v5),
        .legal  (ok6),
        .is_k28 (k28)
    );

    mlane_dec_four u_four (
        .code  (lo_val_in),
        .val   (v3),
        .legal (ok4),
        .alt7  (a7)
    );

    assign ones6  = 3'($countones(hi));
    assign ones4  = 3'($countones(lo));
    assign hi_pos = (ones6 > 3'd3);
    assign hi_neg = (ones6 < 3'd3);
    assign lo_pos = (ones4 > 3'd2);
    assign lo_neg = (ones4 < 3'd2);

    always_comb begin
        hi_bad_disp = (hi_pos && rd_in == RD_POS) || (hi_neg && rd_in == RD_NEG)
                   || (hi == 6'b111000 && rd_in == RD_POS)
                   || (hi == 6'b000111 && rd_in == RD_NEG);
        if (hi_pos)      rd_mid = RD_POS;
        else if (hi_neg) rd_mid = RD_NEG;
        else             rd_mid = rd_in;

        lo_bad_disp = (lo_pos && rd_mid == RD_POS) || (lo_neg && rd_mid == RD_NEG)
                   || (lo == 4'b1100 && rd_mid == RD_POS)
                   || (lo == 4'b0011 && rd_mid == RD_NEG);
        if (lo_pos)      rd_out = RD_POS;
        else if (lo_neg) rd_out = RD_NEG;
        else             rd_out = rd_mid;
    end

    assign k_shape  = k28 || (a7 && (v5 == 5'd23 || v5 == 5'd27 || v5 == 5'd29 || v5 == 5'd30));
    assign code_ok  = ok6 && ok4;
    assign k_out    = code_ok && k_shape;
    assign err_out  = !code_ok || hi_bad_disp || lo_bad_disp;
    assign byte_out = {v3, v5};
endmodule

// File: rtl/mlane_8b10b_decoder.sv
module mlane_8b10b_decoder
    import mlane_dec_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*SYM_W-1:0]  in_words,
    input  logic                    in_valid,
    output logic [LANES*BYTE_W-1:0] out_bytes,
    output logic [LANES-1:0]        out_k,
    output logic [LANES-1:0]        out_err,
    output logic                    out_valid
);
    localparam int IN_W  = LANES * SYM_W;
    localparam int OUT_W = LANES * BYTE_W;

    rd_e              rd_q, rd_d;
    rd_e              rd_chain [LANES+1];
    logic [OUT_W-1:0] dec_bytes;
    logic [LANES-1:0] dec_k;
    logic [LANES-1:0] dec_err;

    assign rd_chain[0] = rd_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mlane_dec_lane u_lane (
            .sym      (in_words[g*SYM_W +: SYM_W]),
            .rd_in    (rd_chain[g]),
            .byte_out (dec_bytes[g*BYTE_W +: BYTE_W]),
            .k_out    (dec_k[g]),
            .err_out  (dec_err[g]),
            .rd_out   (rd_chain[g+1])
        );
    end

    always_comb begin
        rd_d = rd_q;
        unique case (rd_q)
            RD_NEG: if (in_valid && rd_chain[LANES] == RD_POS) rd_d = RD_POS;
            RD_POS: if (in_valid && rd_chain[LANES] == RD_NEG) rd_d = RD_NEG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= RD_NEG;
        else        rd_q <= rd_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bytes <= '0;
            out_k     <= '0;
            out_err   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_bytes <= dec_bytes;
                out_k     <= dec_k;
                out_err   <= dec_err;
            end
        end
    end

    logic unused_width;
    assign unused_width = (IN_W == 0);
endmodule

// File: rtl/mlane_8b10b_decoder_chk.sv
module mlane_8b10b_decoder_chk
    import mlane_dec_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES*SYM_W-1:0]  in_words,
    input logic                    in_valid,
    input logic [LANES*BYTE_W-1:0] out_bytes,
    input logic [LANES-1:0]        out_k,
    input logic [LANES-1:0]        out_err,
    input logic                    out_valid,
    input rd_e                     rd_state
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_r1: assert (!out_valid && out_k == '0 && out_err == '0 && out_bytes == '0
                                && rd_state == RD_NEG);
        end
    end

    p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_bytes) && $stable(out_k) && $stable(out_err)));
    p_idle_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(rd_state));

    p_neg_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_state == RD_NEG && $countones(in_words[9:4]) == 2) |=> out_err[0]);
    p_pos_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_state == RD_POS && $countones(in_words[9:4]) == 4) |=> out_err[0]);

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        p_bad_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && ($countones(in_words[g*SYM_W+4 +: 6]) < 2
                       || $countones(in_words[g*SYM_W+4 +: 6]) > 4))
            |=> (out_err[g] && !out_k[g]));
        p_bad_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (in_words[g*SYM_W +: 4] == 4'b0000 || in_words[g*SYM_W +: 4] == 4'b1111))
            |=> (out_err[g] && !out_k[g]));
        p_comma_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (in_words[g*SYM_W +: SYM_W] == 10'b0011111010
                       || in_words[g*SYM_W +: SYM_W] == 10'b1100000101))
            |=> (out_k[g] && out_bytes[g*BYTE_W +: BYTE_W] == 8'hBC));
    end
endmodule

bind mlane_8b10b_decoder mlane_8b10b_decoder_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_words  (in_words),
    .in_valid  (in_valid),
    .out_bytes (out_bytes),
    .out_k     (out_k),
    .out_err   (out_err),
    .out_valid (out_valid),
    .rd_state  (rd_q)
);

// File: tb/mlane_8b10b_decoder_test.sv
module mlane_8b10b_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 2;
    localparam int NVEC       = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b1;
    logic [LANES*10-1:0] in_words = '0;
    logic                in_valid = 1'b0;
    logic [LANES*8-1:0]  out_bytes;
    logic [LANES-1:0]    out_k;
    logic [LANES-1:0]    out_err;
    logic                out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // {lane1 symbol, lane0 symbol, lane1 byte, lane0 byte, k[1:0], err[1:0]}
    localparam logic [39:0] VEC [NVEC] = '{
        {10'b1100000101, 10'b0011111010, 8'hBC, 8'hBC, 2'b11, 2'b00},
        {10'b1001110100, 10'b1010101010, 8'h00, 8'hB5, 2'b00, 2'b00},
        {10'b1110001100, 10'b1100011001, 8'h67, 8'h23, 2'b00, 2'b00},
        {10'b1110101000, 10'b0011110100, 8'hF7, 8'h1C, 2'b11, 2'b00},
        {10'b1010101010, 10'b1001111010, 8'hB5, 8'hA0, 2'b00, 2'b00},
        {10'b0111101000, 10'b1100000110, 8'hFE, 8'h3C, 2'b11, 2'b00},
        {10'b1010101010, 10'b0110001011, 8'hB5, 8'h00, 2'b00, 2'b01},
        {10'b1010101111, 10'b0000001010, 8'h00, 8'h00, 2'b00, 2'b11},
        {10'b1100000101, 10'b1010101010, 8'hBC, 8'hB5, 2'b10, 2'b00},
        {10'b1110001010, 10'b1001111010, 8'h00, 8'hA0, 2'b00, 2'b10},
        {10'b1100011001, 10'b0001110011, 8'h23, 8'h67, 2'b00, 2'b00},
        {10'b1010101010, 10'b1100000101, 8'hB5, 8'hBC, 2'b01, 2'b00}
    };

    mlane_8b10b_decoder #(.LANES(LANES)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_words  (in_words),
        .in_valid  (in_valid),
        .out_bytes (out_bytes),
        .out_k     (out_k),
        .out_err   (out_err),
        .out_valid (out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string vec_tag(int i);
        case (i)
            0:  return "R4 R7";
            1:  return "R3 R7";
            2:  return "R3 R6";
            3:  return "R4";
            4:  return "R3 R8";
            5:  return "R4 R8";
            6:  return "R6";
            7:  return "R5";
            8:  return "R9";
            9:  return "R6";
            10: return "R6";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] eb, input logic [1:0] ek,
                         input logic [1:0] ee, input logic ev);
        logic [15:0] mask;
        mask = {{8{~ee[1]}}, {8{~ee[0]}}};
        n_checks++;
        if (out_valid !== ev || out_k !== ek || out_err !== ee
            || ((out_bytes & mask) !== (eb & mask))) begin
            n_fail++;
            $display("FAIL %s: valid=%b k=%b err=%b bytes=%h expected valid=%b k=%b err=%b bytes=%h",
                     tag, out_valid, out_k, out_err, out_bytes & mask, ev, ek, ee, eb & mask);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", 16'h0000, 2'b00, 2'b00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            in_words = VEC[i][39:20];
            in_valid = 1'b1;
            @(negedge clk);
            check(vec_tag(i), VEC[i][19:4], VEC[i][3:2], VEC[i][1:0], 1'b1);
        end

        // R2 R8: idle cycles with garbage do not update outputs or disparity
        in_words = 20'hFFFFF;
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 valid drops", 16'hB5BC, 2'b01, 2'b00, 1'b0);
        @(negedge clk);
        check("R2 outputs held", 16'hB5BC, 2'b01, 2'b00, 1'b0);
        in_words = {10'b1100000101, 10'b0011111010};
        in_valid = 1'b1;
        @(negedge clk);
        check("R8 idle keeps disparity", 16'hBCBC, 2'b11, 2'b00, 1'b1);

        // leave disparity positive, then reset mid-stream
        in_words = {10'b1010101010, 10'b1001111010};
        @(negedge clk);
        check("R3 before reset", 16'hB5A0, 2'b00, 2'b00, 1'b1);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1 async reset", 16'h0000, 2'b00, 2'b00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        in_words = {10'b1100000101, 10'b0011111010};
        in_valid = 1'b1;
        @(negedge clk);
        check("R1 disparity negative after reset", 16'hBCBC, 2'b11, 2'b00, 1'b1);
        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule